// File: doc/BRIEF.md
# Pipelined Prime Sieve Filter

This block filters a stream of unsigned integers so that only primes come out. It is a linear chain of registered stages. Each stage owns one fixed prime divisor: the first stage uses 2, the next uses 3, then 5, and so on. An item passes through every stage in order, one stage per clock. A stage tags an item as composite when the item is a proper multiple of that stage's divisor. The tag is a flag bit carried next to the unchanged value. An item that already carries the tag passes through without another test.

Tagged items are not removed early. Every stage forwards every item in lockstep, so the spacing of the stream stays regular all the way through. A final drop stage then lets only untagged items reach the output.

The result is exact for inputs from 2 up to one less than the square of the next prime after the last divisor. With the default of four stages that limit is 121. Values outside that range go through the same rules but are not guaranteed to be prime when emitted.

The input and output are plain valid/data streams. There is no back-pressure. The consumer must take `out_data` on every clock where `out_valid` is high. Cycles where `in_valid` is low simply leave a gap in the stream.

Top module: `prime_sieve_pipe`

## Requirements
- R1: `rst_n` is an asynchronous reset, active low. While it is low, `out_valid` is low. After release, `out_valid` stays low until an accepted item has crossed the whole chain.
- R2: Stage k (counting from 0) uses the k-th prime, starting at 2, as its divisor. With the default `NUM_STAGES` of 4 the divisors are 2, 3, 5 and 7.
- R3: An untagged item that is a multiple of a stage's divisor, and is not equal to that divisor, is tagged by that stage. A tagged item never reaches the output. For example, 4, 9, 25, 49 and 119 are dropped.
- R4: An untagged item that equals a stage's divisor, or that the divisor does not divide, leaves that stage untagged. For example, 2, 3, 5 and 7 are all emitted.
- R5: Once an item is tagged, every later stage forwards it with the tag still set, whatever its value.
- R6: An item sampled at rising edge t with `in_valid` high is presented on the output after edge t+NUM_STAGES-1, with `out_data` equal to the input value. N back-to-back items therefore complete within N+NUM_STAGES-1 edges.
- R7: The block accepts one item on every edge with no back-pressure and keeps the items in order. `in_data` is ignored when `in_valid` is low, and such a cycle never produces an output.
- R8: Feeding 2, 3, 4, 5, 6, 7, 8, 9, 10 on consecutive edges yields exactly 2, 3, 5, 7 on the output.
- R9: For inputs from 2 to q*q-1, where q is the next prime after the last divisor (q*q = 121 by default), exactly the primes are emitted. For example, 113 is emitted and 119 is dropped.
- R10: An input above the supported range that no divisor in the chain divides is still emitted. For example, 121 is emitted with the default parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present this cycle |
| in_data | input | W | Unsigned input value |
| out_valid | output | 1 | Surviving (untagged) item present this cycle |
| out_data | output | W | Value of the surviving item |

## Verification
Every output is due exactly NUM_STAGES-1 edges after the edge that samples its input. The bench drives each input on a falling edge, and the first stage captures it on the next rising edge. The bench therefore checks each item's result on the falling edge NUM_STAGES cycles after driving it, and at that moment it expects either the value or an empty slot. A directed single-item test confirms that the slot one cycle earlier is still empty. A reset test confirms that `out_valid` drops immediately when reset is applied in the middle of a stream, and that nothing already in flight appears after reset is released.

// File: rtl/sieve_pkg.sv
package sieve_pkg;

  // Returns the idx-th prime (idx 0 -> 2). Used at elaboration only.
  function automatic int nth_prime(input int idx);
    int found;
    int cand;
    int res;
    found = 0;
    cand  = 2;
    res   = 0;
    while (res == 0) begin
      bit is_p;
      is_p = 1'b1;
      for (int d = 2; d * d <= cand; d++) begin
        if (cand % d == 0) is_p = 1'b0;
      end
      if (is_p) begin
        if (found == idx) res = cand;
        found++;
      end
      cand++;
    end
    return res;
  endfunction

endpackage

// File: rtl/sieve_stage.sv
module sieve_stage #(
  parameter int W       = 16,
  parameter int DIVISOR = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  input  logic         up_flag,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  output logic         dn_flag,
  output logic [W-1:0] dn_data
);
  localparam logic [W-1:0] DIV_W = W'(DIVISOR);

  logic hit;

  // A tagged item skips the test; an equal value is the prime itself.
  always_comb begin
    hit = 1'b0;
    if (!up_flag) begin
      hit = ((up_data % DIV_W) == '0) && (up_data != DIV_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_flag  <= 1'b0;
      dn_data  <= '0;
    end else begin
      dn_valid <= up_valid;
      if (up_valid) begin
        dn_flag <= up_flag | hit;
        dn_data <= up_data;
      end
    end
  end
endmodule

// File: rtl/sieve_drop.sv
module sieve_drop #(
  parameter int W = 16
) (
  input  logic         tail_valid,
  input  logic         tail_flag,
  input  logic [W-1:0] tail_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  assign out_valid = tail_valid & ~tail_flag;
  assign out_data  = tail_data;
endmodule

// File: rtl/prime_sieve_pipe.sv
module prime_sieve_pipe #(
  parameter int W          = 16,
  parameter int NUM_STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  import sieve_pkg::*;

  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] st_valid;
  logic [NUM_STAGES-1:0] st_flag;
  logic [W-1:0]          st_data [NUM_STAGES];

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    localparam int DIV_K = nth_prime(k);
    if (k == 0) begin : g_head
      sieve_stage #(.W(W), .DIVISOR(DIV_K)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_valid(in_valid),
        .up_flag (1'b0),
        .up_data (in_data),
        .dn_valid(st_valid[k]),
        .dn_flag (st_flag[k]),
        .dn_data (st_data[k])
      );
    end else begin : g_body
      sieve_stage #(.W(W), .DIVISOR(DIV_K)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_valid(st_valid[k-1]),
        .up_flag (st_flag[k-1]),
        .up_data (st_data[k-1]),
        .dn_valid(st_valid[k]),
        .dn_flag (st_flag[k]),
        .dn_data (st_data[k])
      );
    end
  end

  sieve_drop #(.W(W)) u_drop (
    .tail_valid(st_valid[LAST]),
    .tail_flag (st_flag[LAST]),
    .tail_data (st_data[LAST]),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/prime_sieve_pipe_chk.sv
module prime_sieve_pipe_chk #(
  parameter int W          = 16,
  parameter int NUM_STAGES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [W-1:0]          in_data,
  input logic                  out_valid,
  input logic [W-1:0]          out_data,
  input logic [NUM_STAGES-1:0] st_valid,
  input logic [NUM_STAGES-1:0] st_flag
);
  import sieve_pkg::*;

  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] vq;
  logic [W-1:0]          dq [NUM_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= '0;
      for (int i = 0; i < NUM_STAGES; i++) dq[i] <= '0;
    end else begin
      vq[0] <= in_valid;
      dq[0] <= in_data;
      for (int i = 1; i < NUM_STAGES; i++) begin
        vq[i] <= vq[i-1];
        dq[i] <= dq[i-1];
      end
    end
  end

  logic out_composite;
  logic due_is_div;
  always_comb begin
    out_composite = 1'b0;
    due_is_div    = 1'b0;
    for (int j = 0; j < NUM_STAGES; j++) begin
      if ((out_data % W'(nth_prime(j))) == '0 && out_data != W'(nth_prime(j)))
        out_composite = 1'b1;
      if (dq[LAST] == W'(nth_prime(j)))
        due_is_div = 1'b1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_no_slot_without_item_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> vq[LAST]);

  assert_latency_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == dq[LAST]);

  assert_no_composite_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_composite);

  assert_divisor_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vq[LAST] && due_is_div) |-> out_valid);

  for (genvar k = 0; k < LAST; k++) begin : g_keep
    assert_tag_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid[k] && st_flag[k]) |=> (st_valid[k+1] && st_flag[k+1]));
  end
endmodule

bind prime_sieve_pipe prime_sieve_pipe_chk #(.W(W), .NUM_STAGES(NUM_STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data),
  .st_valid (st_valid),
  .st_flag  (st_flag)
);

// File: tb/prime_sieve_pipe_tb.sv
module prime_sieve_pipe_tb;
  localparam int W = 16;
  localparam int P = 4;
  localparam int NV = 17;

  typedef struct packed {
    logic         vld;
    logic [W-1:0] data;
    logic         keep;
    logic [3:0]   req;
  } vec_t;

  // Sieve expectations with divisors 2,3,5,7; range limit 121.
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'd2,   1'b1, 4'd8},  // R8 / R4
    '{1'b1, 16'd3,   1'b1, 4'd8},  // R8
    '{1'b1, 16'd4,   1'b0, 4'd8},  // R8 / R3
    '{1'b1, 16'd5,   1'b1, 4'd8},  // R8
    '{1'b1, 16'd6,   1'b0, 4'd5},  // R5: tagged at 2, stays tagged at 3
    '{1'b1, 16'd7,   1'b1, 4'd4},  // R4
    '{1'b1, 16'd8,   1'b0, 4'd8},  // R8
    '{1'b1, 16'd9,   1'b0, 4'd3},  // R3
    '{1'b1, 16'd10,  1'b0, 4'd8},  // R8
    '{1'b0, 16'd11,  1'b0, 4'd7},  // R7: gap, data ignored
    '{1'b1, 16'd11,  1'b1, 4'd9},  // R9
    '{1'b1, 16'd25,  1'b0, 4'd3},  // R3
    '{1'b1, 16'd49,  1'b0, 4'd2},  // R2: only the fourth stage catches it
    '{1'b1, 16'd97,  1'b1, 4'd9},  // R9
    '{1'b1, 16'd113, 1'b1, 4'd9},  // R9
    '{1'b1, 16'd119, 1'b0, 4'd9},  // R9
    '{1'b1, 16'd121, 1'b1, 4'd10}  // R10
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic [W-1:0] out_data;

  int checks;
  int fails;

  prime_sieve_pipe #(.W(W), .NUM_STAGES(P)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string tag(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string rq, input logic ev, input logic [W-1:0] ed);
    checks++;
    if (out_valid !== ev || (ev && out_data !== ed)) begin
      fails++;
      $display("FAIL %s: got valid=%0b data=%0d, expected valid=%0b data=%0d",
               rq, out_valid, out_data, ev, ed);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got run still active, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks   = 0;
    fails    = 0;
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_data  = 16'd3;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, '0);   // reset holds the output idle despite input
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (P + 1) idle_cycle();
    check("R1", 1'b0, '0);

    // Table walk: drive item i at a falling edge, check it P falling edges later.
    for (int i = 0; i < NV + P; i++) begin
      @(negedge clk);
      if (i >= P) check(tag(int'(VECS[i-P].req)), VECS[i-P].keep, VECS[i-P].data);
      if (i < NV) begin
        in_valid = VECS[i].vld;
        in_data  = VECS[i].data;
      end else begin
        in_valid = 1'b0;
        in_data  = '0;
      end
    end

    // R6: single item, output due exactly P falling edges after driving it.
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'd13;
    for (int j = 1; j <= P; j++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'd4;
      if (j < P) check("R6", 1'b0, '0);
      else       check("R6", 1'b1, 16'd13);
    end

    // R7: data toggling with valid low never produces output.
    for (int j = 0; j < P + 2; j++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = W'(j * 2 + 3);
      if (j >= P) check("R7", 1'b0, '0);
    end

    // R1: reset in the middle of a stream empties the chain at once.
    @(negedge clk); in_valid = 1'b1; in_data = 16'd3;
    @(negedge clk); in_data = 16'd5;
    @(negedge clk); in_data = 16'd7;
    @(negedge clk); in_valid = 1'b0; in_data = '0;
    rst_n = 1'b0;
    #1;
    check("R1", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < P + 1; j++) begin
      @(negedge clk);
      check("R1", 1'b0, '0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule